// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block holds stores on their way from a core or cache to a bus controller. Each store names a 16-byte aligned block and carries a full 16-byte data lane, one enable per byte, and two per-store attributes: whether its region permits merging, and whether it is non-bufferable. The buffer keeps up to eight entries in a ring. It always presents the oldest entry on a write port to memory and holds that entry there until the memory side accepts it.

Merging happens only when both the global merge control and the store's region attribute allow it. The store must also find a live, mergeable entry for the same block other than the one currently offered to memory. A merged store overwrites only the bytes it enables. Because of this, a later store can reach memory together with an older entry, ahead of stores accepted between them. With global merging off, every store gets its own entry, so writes leave in exactly the order they were accepted.

A non-bufferable store stalls the producer until memory has taken it. A drain request stops intake until every entry has gone out, and then raises a single-cycle completion pulse.

Top module: `coal_wbuf`

## Requirements
- R1: After synchronous reset the buffer is empty: `wb_empty`=1, `mem_req`=0, `st_stall`=0, `drain_done`=0.
- R2: The buffer holds 8 entries, each covering one 16-byte aligned block named by `st_blk`. A store is taken in a cycle where `st_valid`=1 and `st_stall`=0. Bytes whose enable is 0 in a freshly allocated entry read as zero on `mem_data`.
- R3: When all 8 entries are occupied and the offered store cannot merge, `st_stall` is 1 and the store is not taken.
- R4: A store merges when `cfg_merge_en`=1 and `st_merge_ok`=1, the store is not non-bufferable, and a live entry for the same block exists that was allocated with merging allowed and is not the entry offered to memory. Merging replaces only the enabled bytes (byte k is `st_data[8k+7:8k]`, enable `st_be[k]`) and ORs `st_be` into the entry's mask.
- R5: With `cfg_merge_en`=0, no store merges, and memory writes occur in acceptance order whatever `st_merge_ok` says.
- R6: `mem_req` is 1 whenever an entry is held. The port shows the oldest entry, with `mem_blk`, `mem_be` and `mem_data` stable until a cycle with `mem_ack`=1 retires it. The offered entry accepts no merges.
- R7: A non-bufferable store (`st_nb`=1) takes its own entry and is never merged into. `st_stall` is 1 from the cycle after it is taken through the cycle in which memory acknowledges it, and it is released in the cycle after that.
- R8: After a cycle with `drain_req`=1, `st_stall` is 1 until `drain_done` pulses. `drain_done` is 1 for one cycle, the first one in which the buffer is empty.
- R9: `wb_empty` is 1 exactly when no entry is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_merge_en | input | 1 | Global merge enable |
| st_valid | input | 1 | Store offered this cycle |
| st_blk | input | 28 | Block address (byte address divided by 16) |
| st_be | input | 16 | Byte enables of the store |
| st_data | input | 128 | Store data lane |
| st_merge_ok | input | 1 | Region permits merging for this store |
| st_nb | input | 1 | Store is non-cacheable and non-bufferable |
| st_stall | output | 1 | Store not taken; producer must hold it |
| drain_req | input | 1 | Request to empty the buffer |
| drain_done | output | 1 | One-cycle pulse: drain complete |
| wb_empty | output | 1 | No entries held |
| mem_req | output | 1 | Memory write request |
| mem_blk | output | 28 | Block address of the write |
| mem_be | output | 16 | Byte mask of the write |
| mem_data | output | 128 | Data of the write |
| mem_ack | input | 1 | Memory accepts the offered write |

## Verification
The hardest case to reach is a merge into an entry that sits deep in the ring while older entries for other blocks are still waiting. That is the only way writes leave out of order, and it needs a full-ish ring, slow acknowledgement and repeated block addresses all at the same time. The stimulus confines addresses to three or four blocks and acknowledges only one cycle in five, so entries pile up and merges into middle entries happen often. Separate phases hold acknowledgement off entirely to reach the full-ring stall, and mix in non-bufferable stores and drain requests while merges are in flight.

// File: rtl/cwb_pkg.sv
`timescale 1ns/1ps
package cwb_pkg;
    parameter int SLOTS      = 8;
    parameter int LANE_BYTES = 16;
    parameter int BLK_W      = 28;

    localparam int DATA_W = LANE_BYTES * 8;
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W  = $clog2(SLOTS + 1);

    typedef logic [BLK_W-1:0]      blk_t;
    typedef logic [LANE_BYTES-1:0] be_t;
    typedef logic [DATA_W-1:0]     line_t;
    typedef logic [IDX_W-1:0]      idx_t;
    typedef logic [CNT_W-1:0]      cnt_t;

    typedef struct packed {
        logic  live;
        logic  mergeable;
        logic  nb;
        blk_t  blk;
        be_t   be;
        line_t data;
    } slot_t;

    // Replace the bytes selected by en, keep the others
    function automatic line_t blend(line_t old, line_t nw, be_t en);
        line_t r;
        for (int b = 0; b < LANE_BYTES; b++)
            r[b*8 +: 8] = en[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
        return r;
    endfunction

    function automatic idx_t bump(idx_t p);
        return (p == idx_t'(SLOTS - 1)) ? '0 : p + idx_t'(1);
    endfunction
endpackage

// File: rtl/cwb_match.sv
`timescale 1ns/1ps
module cwb_match
    import cwb_pkg::*;
(
    input  slot_t slots [SLOTS],
    input  idx_t  head,
    input  blk_t  probe,
    output logic  hit,
    output idx_t  hit_idx
);
    logic [SLOTS-1:0] cand;

    for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
        assign cand[i] = slots[i].live && slots[i].mergeable && !slots[i].nb &&
                         (slots[i].blk == probe) && (idx_t'(i) != head);
    end

    always_comb begin
        hit     = |cand;
        hit_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--)
            if (cand[i]) hit_idx = idx_t'(i);
    end
endmodule

// File: rtl/cwb_slots.sv
`timescale 1ns/1ps
module cwb_slots
    import cwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  slot_t fresh,
    input  logic  merge,
    input  idx_t  merge_idx,
    input  be_t   merge_be,
    input  line_t merge_data,
    input  logic  retire,
    output slot_t slots [SLOTS],
    output idx_t  head,
    output cnt_t  count
);
    idx_t tail;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        end else begin
            if (merge) begin
                slots[merge_idx].data <= blend(slots[merge_idx].data, merge_data, merge_be);
                slots[merge_idx].be   <= slots[merge_idx].be | merge_be;
            end
            if (retire) begin
                slots[head].live <= 1'b0;
                head             <= bump(head);
            end
            if (alloc) begin
                slots[tail] <= fresh;
                tail        <= bump(tail);
            end
            unique case ({alloc, retire})
                2'b10:   count <= count + cnt_t'(1);
                2'b01:   count <= count - cnt_t'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (count == cnt_t'(SLOTS)) |-> !alloc);

    assert_retire_held_R6: assert property (@(posedge clk) disable iff (rst)
        retire |-> (count != '0));
endmodule

// File: rtl/cwb_ctrl.sv
`timescale 1ns/1ps
module cwb_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic accept_nb,
    input  logic retire_nb,
    input  logic drain_req,
    input  logic empty,
    output logic nb_busy,
    output logic drain_pend,
    output logic drain_done
);
    assign drain_done = drain_pend && empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            nb_busy    <= 1'b0;
            drain_pend <= 1'b0;
        end else begin
            if (accept_nb)      nb_busy <= 1'b1;
            else if (retire_nb) nb_busy <= 1'b0;
            drain_pend <= drain_req || (drain_pend && !empty);
        end
    end

    assert_nb_single_R7: assert property (@(posedge clk) disable iff (rst)
        nb_busy |-> !accept_nb);
endmodule

// File: rtl/coal_wbuf.sv
`timescale 1ns/1ps
module coal_wbuf
    import cwb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_merge_en,
    input  logic        st_valid,
    input  logic [BLK_W-1:0]      st_blk,
    input  logic [LANE_BYTES-1:0] st_be,
    input  logic [DATA_W-1:0]     st_data,
    input  logic        st_merge_ok,
    input  logic        st_nb,
    output logic        st_stall,
    input  logic        drain_req,
    output logic        drain_done,
    output logic        wb_empty,
    output logic        mem_req,
    output logic [BLK_W-1:0]      mem_blk,
    output logic [LANE_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]     mem_data,
    input  logic        mem_ack
);
    slot_t slots [SLOTS];
    idx_t  head;
    cnt_t  count;
    logic  hit;
    idx_t  hit_idx;
    logic  nb_busy, drain_pend;
    logic  full, may_merge, merge_cand, accept, do_merge, do_alloc, retire;
    slot_t fresh, head_slot;

    assign head_slot  = slots[head];
    assign full       = (count == cnt_t'(SLOTS));
    assign wb_empty   = (count == '0);
    assign may_merge  = cfg_merge_en && st_merge_ok && !st_nb;
    assign merge_cand = may_merge && hit;
    assign st_stall   = nb_busy || drain_pend || (st_valid && !merge_cand && full);
    assign accept     = st_valid && !st_stall;
    assign do_merge   = accept && merge_cand;
    assign do_alloc   = accept && !merge_cand;
    assign mem_req    = !wb_empty;
    assign retire     = mem_req && mem_ack;
    assign mem_blk    = head_slot.blk;
    assign mem_be     = head_slot.be;
    assign mem_data   = head_slot.data;

    always_comb begin
        fresh.live      = 1'b1;
        fresh.mergeable = may_merge;
        fresh.nb        = st_nb;
        fresh.blk       = st_blk;
        fresh.be        = st_be;
        fresh.data      = blend('0, st_data, st_be);
    end

    cwb_match u_match (
        .slots   (slots),
        .head    (head),
        .probe   (st_blk),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    cwb_slots u_slots (
        .clk        (clk),
        .rst        (rst),
        .alloc      (do_alloc),
        .fresh      (fresh),
        .merge      (do_merge),
        .merge_idx  (hit_idx),
        .merge_be   (st_be),
        .merge_data (st_data),
        .retire     (retire),
        .slots      (slots),
        .head       (head),
        .count      (count)
    );

    cwb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .accept_nb  (accept && st_nb),
        .retire_nb  (retire && head_slot.nb),
        .drain_req  (drain_req),
        .empty      (wb_empty),
        .nb_busy    (nb_busy),
        .drain_pend (drain_pend),
        .drain_done (drain_done)
    );

    assert_head_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_blk) && $stable(mem_be) && $stable(mem_data)));

    assert_nb_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_stall && st_nb) |=> st_stall);

    assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> !mem_req);

    assert_drain_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        drain_req |=> st_stall);

    assert_empty_idle_R9: assert property (@(posedge clk) disable iff (rst)
        wb_empty |-> !mem_req);
endmodule

// File: tb/coal_wbuf_tb.sv
`timescale 1ns/1ps
module coal_wbuf_tb;
    import cwb_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_merge_en = 1'b0, st_valid = 1'b0, st_merge_ok = 1'b0, st_nb = 1'b0;
    logic drain_req = 1'b0, mem_ack = 1'b0;
    blk_t  st_blk = '0;
    be_t   st_be = '0;
    line_t st_data = '0;
    logic  st_stall, drain_done, wb_empty, mem_req;
    blk_t  mem_blk;
    be_t   mem_be;
    line_t mem_data;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    coal_wbuf u_dut (
        .clk(clk), .rst(rst), .cfg_merge_en(cfg_merge_en), .st_valid(st_valid),
        .st_blk(st_blk), .st_be(st_be), .st_data(st_data), .st_merge_ok(st_merge_ok),
        .st_nb(st_nb), .st_stall(st_stall), .drain_req(drain_req), .drain_done(drain_done),
        .wb_empty(wb_empty), .mem_req(mem_req), .mem_blk(mem_blk), .mem_be(mem_be),
        .mem_data(mem_data), .mem_ack(mem_ack)
    );

    typedef struct {
        blk_t  blk;
        be_t   be;
        line_t data;
        bit    mrg;
        bit    nb;
    } ment_t;

    ment_t q[$];
    bit m_nb = 0;
    bit m_dp = 0;

    function automatic line_t put_bytes(line_t old, line_t nw, be_t en);
        line_t r = old;
        for (int k = 0; k < LANE_BYTES; k++)
            if (en[k]) r[k*8 +: 8] = nw[k*8 +: 8];
        return r;
    endfunction

    task automatic chk(string req, string what, line_t act, line_t exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // Compare this cycle's outputs, then advance the model to the next edge
    task automatic step_model(string tag);
        int  hit = -1;
        bit  mok, mc, e, stall, done, acc, ret, retnb;
        for (int i = 1; i < q.size(); i++)
            if (hit < 0 && q[i].mrg && !q[i].nb && q[i].blk == st_blk) hit = i;
        mok   = cfg_merge_en && st_merge_ok && !st_nb;
        mc    = mok && (hit >= 0);
        e     = (q.size() == 0);
        stall = m_nb || m_dp || (st_valid && !mc && q.size() == SLOTS);
        done  = m_dp && e;
        chk(tag,  "st_stall",   line_t'(st_stall),   line_t'(stall));
        chk("R9", "wb_empty",   line_t'(wb_empty),   line_t'(e));
        chk("R6", "mem_req",    line_t'(mem_req),    line_t'(!e));
        chk("R8", "drain_done", line_t'(drain_done), line_t'(done));
        if (!e) begin
            chk(tag, "mem_blk",  line_t'(mem_blk), line_t'(q[0].blk));
            chk(tag, "mem_be",   line_t'(mem_be),  line_t'(q[0].be));
            chk(tag, "mem_data", mem_data,         q[0].data);
        end
        acc   = st_valid && !stall;
        ret   = !e && mem_ack;
        retnb = ret && q[0].nb;
        if (acc && mc) begin
            q[hit].data = put_bytes(q[hit].data, st_data, st_be);
            q[hit].be   = q[hit].be | st_be;
        end
        if (ret) void'(q.pop_front());
        if (acc && !mc)
            q.push_back(ment_t'{st_blk, st_be, put_bytes('0, st_data, st_be), mok, st_nb});
        if (retnb) m_nb = 0;
        if (acc && st_nb) m_nb = 1;
        m_dp = drain_req || (m_dp && !e);
    endtask

    task automatic phase(string tag, int cycles, bit cfg, int vpct, int nblk,
                         int mpct, int npct, int apct, int dpct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            cfg_merge_en = cfg;
            st_valid     = ($urandom_range(99) < vpct);
            st_blk       = blk_t'($urandom_range(nblk - 1));
            st_be        = be_t'($urandom);
            st_data      = {$urandom, $urandom, $urandom, $urandom};
            st_merge_ok  = ($urandom_range(99) < mpct);
            st_nb        = ($urandom_range(99) < npct);
            mem_ack      = ($urandom_range(99) < apct);
            drain_req    = ($urandom_range(99) < dpct);
            #1;
            step_model(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state right after reset
        chk("R1", "st_stall",   line_t'(st_stall),   '0);
        chk("R1", "wb_empty",   line_t'(wb_empty),   line_t'(1));
        chk("R1", "mem_req",    line_t'(mem_req),    '0);
        chk("R1", "drain_done", line_t'(drain_done), '0);
        // R2: eight separate stores fill the ring with no acknowledge
        phase("R2", 8,    1'b0, 100, 1 << 20, 0,   0,  0,  0);
        // R3: full ring, new blocks cannot merge, intake stalls
        phase("R3", 6,    1'b1, 100, 1 << 20, 100, 0,  0,  0);
        // R6: oldest-first retirement under mixed acknowledge
        phase("R6", 300,  1'b0, 70,  16,      50,  0,  40, 0);
        // R4: merging into deep entries on a few hot blocks
        phase("R4", 2000, 1'b1, 90,  3,       80,  0,  20, 0);
        // R5: global merge off keeps strict order despite region permission
        phase("R5", 1000, 1'b0, 90,  3,       100, 0,  50, 0);
        // R7: non-bufferable stores hold the stall until acknowledged
        phase("R7", 1000, 1'b1, 80,  4,       80,  10, 50, 0);
        // R8: drain requests during traffic
        phase("R8", 1000, 1'b1, 80,  4,       70,  3,  40, 5);
        summary();
        $finish;
    end
endmodule